// File: doc/BRIEF.md
# Quadratic Extension Field Multiplier

This block multiplies two elements of the quadratic extension field built over a prime field by adjoining a square root of minus one. An element is written x0 + x1·i with i² = −1, and each coefficient is an integer below the prime modulus. A caller presents both operands' coefficients and the modulus, then pulses start. The block captures them, forms the sums of each operand's two coefficients, and runs three base-field products side by side on three identical bit-serial interleaved double-and-add units. It then finishes the Karatsuba recombination with two single-cycle rounds of modular subtraction. The coefficients of the product appear together with a one-cycle done pulse.

The base products consume one multiplier bit per clock, so one extension-field product costs W + 3 cycles for W-bit coefficients. Squaring has no separate path: the caller supplies the same element as both operands and gets the same cost.

Top module: `fp2_mul`

## Requirements
- R1: While rst_n is low, and after its release until the first completed operation, done is 0 and both c0 and c1 are 0.
- R2: For operands with all coefficients below the modulus p, c0 equals (a0·b0 − a1·b1) mod p.
- R3: For operands with all coefficients below p, c1 equals (a0·b1 + a1·b0) mod p. Internally it is formed as (a0+a1)(b0+b1) − a0·b0 − a1·b1.
- R4: start is accepted on a rising clock edge when the block is idle. done goes high at the (W+3)-th rising edge after the accepting edge: one cycle for sums, W cycles of base products, and two subtraction cycles.
- R5: done is high for exactly one cycle per operation. c0 and c1 change only at the edge that raises done, and they hold their values afterwards until the next completion.
- R6: start pulses that arrive while an operation is in progress are ignored. They neither restart nor alter the running operation.
- R7: The coefficients and modulus are captured at the accepting edge. Later changes on those inputs do not affect the running result.
- R8: Squaring uses the multiply sequence with equal operands. Its result is (a0² − a1²) mod p and (2·a0·a1) mod p, with the same latency as R4.
- R9: Every result coefficient is below p, including when all inputs equal p − 1. The modulus may be any value from 2 up to 2^W − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| modulus | input | W | Prime modulus p |
| a0 | input | W | Real coefficient of first operand |
| a1 | input | W | Imaginary coefficient of first operand |
| b0 | input | W | Real coefficient of second operand |
| b1 | input | W | Imaginary coefficient of second operand |
| c0 | output | W | Real coefficient of product |
| c1 | output | W | Imaginary coefficient of product |
| done | output | 1 | One-cycle completion pulse |

## Verification
Both result coefficients and done become valid together, W + 3 rising edges after the edge that samples start. The bench drives start on a falling edge and counts falling edges until done is seen, expecting W + 4 of them. It reads c0 and c1 at that falling edge, and again one cycle later to confirm the pulse has ended and the values are held. The busy-window tests change the operand inputs and pulse start mid-run, then read the result only at the original completion time.

// File: rtl/fp2_mul.sv
module fp2_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] a0,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] b0,
  input  logic [W-1:0] b1,
  output logic [W-1:0] c0,
  output logic [W-1:0] c1,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int NU = 3;

  typedef enum logic [2:0] {S_IDLE, S_SUM, S_MUL, S_SUB1, S_SUB2} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [W-1:0]  p_q, x0, x1, y0, y1, sx, sy, t0, t1;
  logic [W-1:0]  c0_q, c1_q;
  logic          done_q;
  logic [W-1:0]  mx [NU];
  logic [W-1:0]  my [NU];
  logic [W-1:0]  prod [NU];

  function automatic logic [W-1:0] addm(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic [W-1:0] p);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, p}) s = s - {1'b0, p};
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] subm(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic [W-1:0] p);
    logic [W:0] d;
    d = {1'b0, x} - {1'b0, y};
    if (x < y) d = d + {1'b0, p};
    return d[W-1:0];
  endfunction

  function automatic logic [W-1:0] dbl_add(input logic [W-1:0] r, input logic b,
                                           input logic [W-1:0] x, input logic [W-1:0] p);
    logic [W:0] d, s;
    d = {r, 1'b0};
    if (d >= {1'b0, p}) d = d - {1'b0, p};
    s = d + (b ? {1'b0, x} : '0);
    if (s >= {1'b0, p}) s = s - {1'b0, p};
    return s[W-1:0];
  endfunction

  assign mx[0] = x0;
  assign my[0] = y0;
  assign mx[1] = x1;
  assign my[1] = y1;
  assign mx[2] = sx;
  assign my[2] = sy;

  for (genvar g = 0; g < NU; g++) begin : g_unit
    logic [W-1:0] acc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc <= '0;
      else if (state == S_SUM)
        acc <= '0;
      else if (state == S_MUL)
        acc <= dbl_add(acc, my[g][cnt], mx[g], p_q);
    end
    assign prod[g] = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      p_q    <= '0;
      x0     <= '0;
      x1     <= '0;
      y0     <= '0;
      y1     <= '0;
      sx     <= '0;
      sy     <= '0;
      t0     <= '0;
      t1     <= '0;
      c0_q   <= '0;
      c1_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (state == S_SUB2);
      case (state)
        S_IDLE: if (start) begin
          p_q   <= modulus;
          x0    <= a0;
          x1    <= a1;
          y0    <= b0;
          y1    <= b1;
          state <= S_SUM;
        end
        S_SUM: begin
          sx    <= addm(x0, x1, p_q);
          sy    <= addm(y0, y1, p_q);
          cnt   <= CW'(W - 1);
          state <= S_MUL;
        end
        S_MUL: begin
          if (cnt == '0) state <= S_SUB1;
          else           cnt   <= cnt - 1'b1;
        end
        S_SUB1: begin
          t0    <= subm(prod[0], prod[1], p_q);
          t1    <= subm(prod[2], prod[0], p_q);
          state <= S_SUB2;
        end
        S_SUB2: begin
          c0_q  <= t0;
          c1_q  <= subm(t1, prod[1], p_q);
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign c0   = c0_q;
  assign c1   = c1_q;
  assign done = done_q;
endmodule

// File: rtl/fp2_mul_chk.sv
module fp2_mul_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] c0,
  input logic [W-1:0] c1,
  input logic [W-1:0] p_q
);
  logic [31:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy)           lat <= lat + 1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(c0) && $stable(c1)));

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (c0 < p_q && c1 < p_q));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == 32'(W + 3)));

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind fp2_mul fp2_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(state != S_IDLE),
  .done(done), .c0(c0), .c1(c1), .p_q(p_q)
);

// File: tb/sim_fp2_mul.sv
module sim_fp2_mul;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] P = 16'hFFF1;
  localparam int NV = 8;
  localparam logic [W-1:0] VEC [NV][4] = '{
    '{16'd0,     16'd0,     16'd0,     16'd0},
    '{16'd1,     16'd0,     16'd1,     16'd0},
    '{16'd0,     16'd1,     16'd0,     16'd1},
    '{16'd65520, 16'd65520, 16'd65520, 16'd65520},
    '{16'd12345, 16'd54321, 16'd1111,  16'd2222},
    '{16'd65520, 16'd0,     16'd0,     16'd65520},
    '{16'd40000, 16'd30000, 16'd50000, 16'd60000},
    '{16'd7,     16'd65519, 16'd3,     16'd9}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] modulus = '0, a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic [W-1:0] c0, c1;
  logic done;
  int checks = 0, failures = 0, cycles = 0;

  fp2_mul #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
    .a0(a0), .a1(a1), .b0(b0), .b1(b1), .c0(c0), .c1(c1), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [W-1:0] ref_c0(longint x0, longint x1, longint y0, longint y1, longint p);
    longint m0, m1;
    m0 = (x0 * y0) % p;
    m1 = (x1 * y1) % p;
    return W'((m0 + p - m1) % p);
  endfunction

  function automatic logic [W-1:0] ref_c1(longint x0, longint x1, longint y0, longint y1, longint p);
    return W'((x0 * y1 + x1 * y0) % p);
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] p, input logic [W-1:0] x0, input logic [W-1:0] x1,
                        input logic [W-1:0] y0, input logic [W-1:0] y1);
    @(negedge clk);
    modulus = p; a0 = x0; a1 = x1; b0 = y0; b1 = y1; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input string req, input logic [W-1:0] p, input logic [W-1:0] x0,
                        input logic [W-1:0] x1, input logic [W-1:0] y0, input logic [W-1:0] y1,
                        input bit chk_lat);
    int lat;
    logic [W-1:0] h0, h1;
    launch(p, x0, x1, y0, y1);
    wait_done(lat);
    // done seen at the (W+4)-th falling edge counted from the start-driving one (R4)
    if (chk_lat) check("R4 latency", lat, W + 4);
    check({req, " c0"}, c0, ref_c0(x0, x1, y0, y1, p));
    check({req, " c1"}, c1, ref_c1(x0, x1, y0, y1, p));
    h0 = c0; h1 = c1;
    @(negedge clk);
    if (chk_lat) begin
      check("R5 done pulse ends", done, 0);
      check("R5 c0 held", c0, h0);
      check("R5 c1 held", c1, h1);
    end
  endtask

  initial begin
    int lat;
    logic [W-1:0] h0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 c0 in reset", c0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 c1 after reset", c1, 0);
    check("R1 done after reset", done, 0);

    for (int i = 0; i < NV; i++)
      run_op("R2 R3 vector", P, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], i < 2);

    // R9 all p-1 and a small modulus
    run_op("R9 max operands", P, P - 1, P - 1, P - 1, P - 1, 0);
    run_op("R9 small modulus", 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 1);
    run_op("R9 modulus two", 16'd2, 16'd1, 16'd1, 16'd1, 16'd0, 0);

    // R8 squaring
    run_op("R8 square", P, 16'd31337, 16'd27182, 16'd31337, 16'd27182, 1);
    run_op("R8 square max", P, P - 1, 16'd1, P - 1, 16'd1, 0);

    // R6 R7: change inputs and pulse start mid-run; result must be of the first operands
    launch(P, 16'd1000, 16'd2000, 16'd3000, 16'd4000);
    repeat (4) @(negedge clk);
    modulus = 16'd101; a0 = 16'd5; a1 = 16'd6; b0 = 16'd7; b1 = 16'd8; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(lat);
    check("R6 latency unchanged by restart", lat, W + 4 - 5);
    check("R7 c0 from captured operands", c0, ref_c0(1000, 2000, 3000, 4000, P));
    check("R7 c1 from captured operands", c1, ref_c1(1000, 2000, 3000, 4000, P));
    h0 = c0;
    repeat (W + 8) @(negedge clk);
    check("R6 no second completion", c0, h0);
    check("R5 done stays low while idle", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule